// File: doc/BRIEF.md
# Handshaked Serial Segment Output Port

This block sends one buffered command segment, byte by byte, over a single serial line to an external receiver. When a segment is handed over, the block first places a destination identifier on a parallel bus and pulses an active-low address strobe. An external demultiplexer latches the identifier on this strobe. The strobe is held for as long as a wait-state acknowledge input stays low.

After the strobe, the block raises a data-set-ready output. It then produces an output bit clock, but only while the receiver's data-terminal-ready input (synchronized inside the block) is also high. Serial data changes only as the bit clock falls, so the receiver samples it on the rising edge. The receiver can pause the stream at any bit boundary by dropping its ready line. The clock then parks high.

Segment bytes are fetched through a simple combinational byte-read port addressed by the block. An abort request ends a partial segment at once and raises a sticky abort flag.

Top module: `seg_tx_port`

## Requirements
- R1: After reset the strobe is high, data-set-ready is low, the bit clock is high, the abort flag is low, and both serial data and the identifier bus are 0.
- R2: A start pulse seen in idle with a nonzero byte count drives the strobe low from the next cycle, with the destination identifier on the identifier bus.
- R3: The strobe stays low for one cycle plus one more cycle for every sampled cycle in which the wait acknowledge is low. In the cycle it returns high, data-set-ready is high.
- R4: A start pulse with a byte count of 0, or one that arrives while a segment is in progress, is ignored. No strobe is produced and the running segment is not disturbed.
- R5: The bit clock is high whenever data-set-ready is low. Each bit takes one low cycle followed by at least one high cycle, and a segment of N bytes gives exactly 8·N rising edges.
- R6: Serial data changes only as the bit clock falls. Bytes are read from byte addresses 0 to N-1 in rising order, and each byte is sent with its most significant bit (bit 7) first.
- R7: The bit clock falls only when data-terminal-ready has been high, as delivered through the two-flop synchronizer. While it is low, the clock parks high after finishing a low phase, and no bit is lost when it returns.
- R8: Data-set-ready is high in the single high-phase cycle that follows the last bit's rising edge, and it is low in the next cycle.
- R9: An abort request during the strobe or the data phase makes the next cycle show data-set-ready low, the strobe high, the bit clock high and the abort flag high. The flag holds until the next accepted start, which clears it as the strobe asserts.
- R10: An abort request in idle has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Segment ready pulse |
| dest_id | input | DATA_W | Destination identifier for the segment |
| seg_len | input | ADDR_W | Segment length in bytes |
| abort_req | input | 1 | Request to abandon the current segment |
| rd_addr | output | ADDR_W | Byte address into segment storage |
| rd_data | input | DATA_W | Byte returned by storage (combinational) |
| wait_ack | input | 1 | Wait acknowledge; low stretches the strobe |
| id_bus | output | DATA_W | Identifier bus, driven during the strobe |
| strobe_n | output | 1 | Active-low address strobe |
| dsr | output | 1 | Data-set-ready, active high |
| dtr | input | 1 | Receiver data-terminal-ready, asynchronous |
| bit_clk | output | 1 | Serial bit clock, parked high |
| ser_data | output | 1 | Serial data, changes on bit_clk fall |
| abort_flag | output | 1 | Sticky abort indication |

## Verification
The internal state shows up on the ports almost at once. A wrong bit or byte counter changes the sequence sampled on the rising edges or the count of those edges, and this is visible in the very segment where it happens. A wrong phase register shows up within one cycle as a clock edge outside data-set-ready or without a synchronized ready. A lost done or abort state leaves data-set-ready high past the one-cycle tail, or leaves the abort flag in the wrong level, on the next cycle. The bench uses a receiver model that pauses at random, reassembles the bytes, and times every strobe, edge and drop against the cycle counts given above.

// File: rtl/seg_tx_pkg.sv
package seg_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_XFER = 2'd2
    } tx_state_e;
endpackage

// File: rtl/seg_tx_sync.sv
module seg_tx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/seg_tx_bitsel.sv
module seg_tx_bitsel #(
    parameter int W     = 8,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     word,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    // idx 0 selects the most significant bit
    always_comb begin
        bit_o = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (idx == IDX_W'(W - 1 - i)) bit_o = word[i];
        end
    end
endmodule

// File: rtl/seg_tx_port.sv
module seg_tx_port
    import seg_tx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] dest_id,
    input  logic [ADDR_W-1:0] seg_len,
    input  logic              abort_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              wait_ack,
    output logic [DATA_W-1:0] id_bus,
    output logic              strobe_n,
    output logic              dsr,
    input  logic              dtr,
    output logic              bit_clk,
    output logic              ser_data,
    output logic              abort_flag
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    typedef struct packed {
        tx_state_e         st;
        logic [DATA_W-1:0] dest;
        logic [ADDR_W-1:0] len;
        logic [ADDR_W-1:0] byte_i;
        logic [BIT_W-1:0]  bit_i;
        logic              clk_lvl;
        logic              ser;
        logic              done;
        logic              abort;
    } regs_t;

    localparam regs_t RESET_VAL = '{
        st:      ST_IDLE,
        dest:    '0,
        len:     '0,
        byte_i:  '0,
        bit_i:   '0,
        clk_lvl: 1'b1,
        ser:     1'b0,
        done:    1'b0,
        abort:   1'b0
    };

    regs_t r_d, r_q;
    logic  dtr_s;
    logic  next_bit;

    seg_tx_sync #(.STAGES(SYNC_STAGES)) u_dtr_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dtr),
        .q     (dtr_s)
    );

    seg_tx_bitsel #(.W(DATA_W), .IDX_W(BIT_W)) u_bitsel (
        .word  (rd_data),
        .idx   (r_q.bit_i),
        .bit_o (next_bit)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start && (seg_len != '0)) begin
                    r_d.st      = ST_ADDR;
                    r_d.dest    = dest_id;
                    r_d.len     = seg_len;
                    r_d.byte_i  = '0;
                    r_d.bit_i   = '0;
                    r_d.clk_lvl = 1'b1;
                    r_d.done    = 1'b0;
                    r_d.abort   = 1'b0;
                end
            end
            ST_ADDR: begin
                if (abort_req) begin
                    r_d.st    = ST_IDLE;
                    r_d.abort = 1'b1;
                end else if (wait_ack) begin
                    r_d.st = ST_XFER;
                end
            end
            ST_XFER: begin
                if (abort_req) begin
                    r_d.st      = ST_IDLE;
                    r_d.abort   = 1'b1;
                    r_d.clk_lvl = 1'b1;
                end else if (r_q.clk_lvl) begin
                    if (r_q.done) begin
                        r_d.st = ST_IDLE;
                    end else if (dtr_s) begin
                        r_d.clk_lvl = 1'b0;
                        r_d.ser     = next_bit;
                    end
                end else begin
                    r_d.clk_lvl = 1'b1;
                    if (r_q.bit_i == LAST_BIT) begin
                        r_d.bit_i = '0;
                        if (r_q.byte_i == r_q.len - 1'b1) r_d.done = 1'b1;
                        else                              r_d.byte_i = r_q.byte_i + 1'b1;
                    end else begin
                        r_d.bit_i = r_q.bit_i + 1'b1;
                    end
                end
            end
            default: r_d = RESET_VAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign rd_addr    = r_q.byte_i;
    assign id_bus     = (r_q.st == ST_ADDR) ? r_q.dest : '0;
    assign strobe_n   = (r_q.st != ST_ADDR);
    assign dsr        = (r_q.st == ST_XFER);
    assign bit_clk    = r_q.clk_lvl;
    assign ser_data   = r_q.ser;
    assign abort_flag = r_q.abort;
endmodule

// File: rtl/seg_tx_port_chk.sv
module seg_tx_port_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic abort_req,
    input logic wait_ack,
    input logic strobe_n,
    input logic dsr,
    input logic bit_clk,
    input logic ser_data,
    input logic abort_flag
);
    a_r2_strobe_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n) |-> $past(start));

    a_r3_wait_holds_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && !wait_ack && !abort_req) |=> !strobe_n);

    a_r5_clock_parked_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !dsr |-> bit_clk);

    a_r5_fall_inside_dsr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bit_clk) |-> $past(dsr));

    a_r6_data_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_data) |-> !bit_clk);

    a_r8_dsr_drop_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dsr) |-> (abort_flag || $past(bit_clk)));

    a_r9_abort_quiets_port: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_flag) |-> (!dsr && strobe_n && bit_clk));
endmodule

bind seg_tx_port seg_tx_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .abort_req  (abort_req),
    .wait_ack   (wait_ack),
    .strobe_n   (strobe_n),
    .dsr        (dsr),
    .bit_clk    (bit_clk),
    .ser_data   (ser_data),
    .abort_flag (abort_flag)
);

// File: tb/sim_seg_tx_port.sv
module sim_seg_tx_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] dest_id = '0;
    logic [7:0] seg_len = '0;
    logic       abort_req = 1'b0;
    logic [7:0] rd_addr;
    logic [7:0] rd_data;
    logic       wait_ack = 1'b0;
    logic [7:0] id_bus;
    logic       strobe_n, dsr, bit_clk, ser_data, abort_flag;
    logic       dtr = 1'b1;
    logic [7:0] mem [256];
    logic       h1 = 1'b1, h2 = 1'b1, h3 = 1'b1;
    int         n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    assign rd_data = mem[rd_addr];

    seg_tx_port u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .dest_id(dest_id),
        .seg_len(seg_len), .abort_req(abort_req), .rd_addr(rd_addr),
        .rd_data(rd_data), .wait_ack(wait_ack), .id_bus(id_bus),
        .strobe_n(strobe_n), .dsr(dsr), .dtr(dtr), .bit_clk(bit_clk),
        .ser_data(ser_data), .abort_flag(abort_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic set_dtr(input logic v);
        h3 = h2; h2 = h1; h1 = v; dtr = v;
    endtask

    function automatic logic pick_dtr(input int mode, input int t);
        if (mode == 1) return ($urandom % 4) != 0;
        if (mode == 2) return !(t >= 10 && t < 30);
        return 1'b1;
    endfunction

    task automatic hold_dtr_high();
        @(negedge clk); set_dtr(1'b1);
        repeat (3) begin @(negedge clk); set_dtr(1'b1); end
    endtask

    // one full segment with a receiver model
    task automatic run_seg(input int len, input int w, input int mode, input bit inject);
        logic [7:0] dst;
        logic [7:0] got [256];
        int c, t, rises, last_rise, nbits;
        logic prev;
        dst = 8'($urandom);
        for (int i = 0; i < len; i++) mem[i] = 8'($urandom);
        hold_dtr_high();
        start = 1'b1; dest_id = dst; seg_len = 8'(len); wait_ack = 1'b0;
        @(negedge clk); set_dtr(1'b1);
        start = 1'b0;
        chk(strobe_n == 1'b0, "R2 strobe low", int'(strobe_n), 0);
        chk(id_bus == dst, "R2 identifier", int'(id_bus), int'(dst));
        chk(abort_flag == 1'b0, "R9 flag cleared by start", int'(abort_flag), 0);
        c = 1;
        wait_ack = (c >= w + 1);
        for (int g = 0; g < 1000; g++) begin
            @(negedge clk); set_dtr(1'b1);
            if (strobe_n) break;
            c++;
            wait_ack = (c >= w + 1);
        end
        wait_ack = 1'b0;
        chk(c == w + 1, "R3 strobe length", c, w + 1);
        chk(dsr == 1'b1, "R3 dsr after strobe", int'(dsr), 1);
        prev = bit_clk; rises = 0; last_rise = 0; nbits = 0; t = 0;
        for (int i = 0; i < len; i++) got[i] = '0;
        set_dtr(pick_dtr(mode, t));
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            t++;
            if (!bit_clk && prev)
                chk(h3 == 1'b1, "R7 fall needs synced dtr", int'(h3), 1);
            if (bit_clk && !prev) begin
                got[nbits / 8] = {got[nbits / 8][6:0], ser_data};
                nbits++; rises++; last_rise = t;
            end
            if (inject && t == 6)
                chk(strobe_n == 1'b1, "R4 busy start ignored", int'(strobe_n), 1);
            if (mode == 2 && t == 29)
                chk(bit_clk == 1'b1, "R7 parked high", int'(bit_clk), 1);
            if (!dsr) break;
            prev = bit_clk;
            start = inject && (t == 5);
            if (start) begin dest_id = 8'hA5; seg_len = 8'd3; end
            set_dtr(pick_dtr(mode, t));
        end
        start = 1'b0;
        chk(t == last_rise + 1, "R8 dsr tail", t - last_rise, 1);
        chk(rises == 8 * len, "R5 edge count", rises, 8 * len);
        for (int i = 0; i < len; i++)
            chk(got[i] == mem[i], "R6 byte msb first", int'(got[i]), int'(mem[i]));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(strobe_n == 1'b1 && dsr == 1'b0 && bit_clk == 1'b1 && abort_flag == 1'b0
            && ser_data == 1'b0 && id_bus == 8'h00, "R1 reset state",
            int'({strobe_n, dsr, bit_clk, abort_flag, ser_data}), 5'b10100);
        rst_n = 1'b1;
        @(negedge clk);

        // directed corners
        run_seg(1, 0, 0, 1'b0);
        run_seg(2, 5, 2, 1'b1);
        run_seg(3, 0, 2, 1'b0);

        // zero length start
        start = 1'b1; seg_len = 8'd0; dest_id = 8'h3C;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(strobe_n == 1'b1 && dsr == 1'b0, "R4 zero length ignored", int'(strobe_n), 1);
            @(negedge clk);
        end

        // abort in the data phase
        hold_dtr_high();
        for (int i = 0; i < 4; i++) mem[i] = 8'($urandom);
        start = 1'b1; seg_len = 8'd4; wait_ack = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (7) @(negedge clk);
        abort_req = 1'b1;
        @(negedge clk); abort_req = 1'b0; wait_ack = 1'b0;
        chk(dsr == 1'b0 && bit_clk == 1'b1 && strobe_n == 1'b1, "R9 abort quiets",
            int'({dsr, bit_clk, strobe_n}), 3'b011);
        chk(abort_flag == 1'b1, "R9 abort flag", int'(abort_flag), 1);
        repeat (3) @(negedge clk);
        chk(abort_flag == 1'b1, "R9 flag holds", int'(abort_flag), 1);

        // abort in idle
        abort_req = 1'b1;
        @(negedge clk); abort_req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(abort_flag == 1'b1 && dsr == 1'b0 && strobe_n == 1'b1 && bit_clk == 1'b1,
                "R10 idle abort no effect", int'({abort_flag, dsr, strobe_n, bit_clk}), 4'b1011);
            @(negedge clk);
        end
        run_seg(2, 1, 0, 1'b0);

        // abort during strobe
        start = 1'b1; seg_len = 8'd2; wait_ack = 1'b0;
        @(negedge clk); start = 1'b0;
        abort_req = 1'b1;
        @(negedge clk); abort_req = 1'b0;
        chk(strobe_n == 1'b1 && abort_flag == 1'b1 && dsr == 1'b0, "R9 abort in strobe",
            int'({strobe_n, abort_flag, dsr}), 3'b110);

        // constrained random segments
        for (int k = 0; k < 25; k++)
            run_seg(1 + int'($urandom % 6), int'($urandom % 4), 1, (k % 5) == 0);

        summary();
        $finish;
    end
endmodule